// File: doc/BRIEF.md
# Buck Converter Load-Step Recovery Controller

This block sits between a linear voltage compensator and the power-switch driver of a buck converter. In steady state it drives the switch from a counter-based pulse-width modulator, using the duty word that the linear compensator supplies. When the sampled output voltage leaves a programmable band around the reference on two samples in a row, the block takes the switch over. It holds the switch in the state that opposes the disturbance, finds the output-voltage extremum from the sign of successive sample differences, and then flips the switch once. The flip comes at the instant when the second of two error accumulators has gathered as much as the first one gathered before the extremum.

Once the error has crossed zero, control returns to the linear loop. The block then issues a one-clock preload pulse that carries a corrected duty word, which the linear compensator can load into its integrator. The error sums stand in for capacitor charge, so no inductance or capacitance value is needed. A count of forced-on samples bounds the inductor current. A disturbance in the opposite direction during recovery abandons the recovery at once.

Top module: `cbc_ctrl`

## Requirements
- R1: In linear mode `mode_nl` is 0 and `sw_on` is high for exactly `lin_duty` clock cycles out of every 2^DUTY_W consecutive cycles.
- R2: The error is `vref - vout`. Nonlinear mode starts at a sample whose error exceeds `thresh` in one sign when the previous sample exceeded it in the same sign. A single such sample has no effect.
- R3: In nonlinear mode, for a positive error (undershoot), the switch is forced on until the toggle. For a negative error (overshoot), it is forced off until the toggle.
- R4: The extremum is the first sample after entry at which `vout[n]-vout[n-1]` turns positive (undershoot) or negative (overshoot). The first sum holds |error| from the entry sample up to the sample before the extremum.
- R5: The switch toggles at the first sample, from the extremum on, at which the sum of |error| since the extremum (that sample included) reaches the first sum.
- R6: After the toggle, linear mode resumes at the first sample whose error is <= 0 (undershoot) or >= 0 (overshoot). `preload_vld` pulses for one clock at that same edge.
- R7: `preload_duty` equals the duty captured at entry, plus (undershoot) or minus (overshoot) the first sum shifted right by GAIN_SH. The result saturates to the range 0 to 2^DUTY_W-1.
- R8: The switch stays forced on for at most ON_LIMIT samples after entry. On reaching the limit, an undershoot recovery toggles off early, and an overshoot recovery returns to linear mode with a preload.
- R9: During recovery, a qualified transient of the opposite sign returns the block to linear mode at that sample with no preload. A further transient of the same sign is ignored.
- R10: Mode and forced switch state change only at clock edges where `sample_valid` is high. The effect shows on the outputs right after that edge.
- R11: After reset the block is in linear mode with `preload_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Strobe marking a new output-voltage sample |
| vout | input | VW | Sampled output voltage (unsigned code) |
| vref | input | VW | Reference voltage (unsigned code) |
| thresh | input | VW | Error magnitude that counts as a transient |
| lin_duty | input | DUTY_W | Duty word from the linear compensator |
| sw_on | output | 1 | Main switch on request |
| mode_nl | output | 1 | High while the nonlinear recovery owns the switch |
| preload_vld | output | 1 | One-clock strobe: load `preload_duty` into the linear integrator |
| preload_duty | output | DUTY_W | Corrected duty word for the linear loop |

## Verification
Every mode and forced-switch decision is due one clock after the rising edge that takes a sample. The bench drives each sample on a falling edge and compares `mode_nl` and the forced `sw_on` at the falling edge that follows the capturing edge. The preload strobe is due on the same edge as the return to linear mode. A monitor pops an expected duty word only when the strobe is high, so a pulse that is missing, extra or late is reported. Linear pass-through is measured by counting `sw_on` over a whole modulator period of 2^DUTY_W cycles, so the result does not depend on the counter phase.

// File: rtl/cbc_pkg.sv
// Shared types for the load-step recovery controller.
package cbc_pkg;
    // Controller phase: linear, before extremum, after extremum, after toggle.
    typedef enum logic [1:0] {
        ST_LIN  = 2'd0,
        ST_DIVE = 2'd1,
        ST_HOLD = 2'd2,
        ST_TAIL = 2'd3
    } cbc_state_e;
endpackage

// File: rtl/cbc_detect.sv
// Error and slope front end.
// Computes the signed error vref - vout and its magnitude. Flags a qualified
// transient when two successive samples exceed the threshold in the same sign.
// Reports the sign of the sample-to-sample voltage difference.
// Assumes: registers advance only on smp_vld; outputs are combinational
// from the current sample and the stored previous one.
module cbc_detect #(
    parameter int VW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic [VW-1:0]        vout,
    input  logic [VW-1:0]        vref,
    input  logic [VW-1:0]        thresh,
    output logic signed [VW:0]   err,
    output logic [VW:0]          err_mag,
    output logic                 trig_pos,
    output logic                 trig_neg,
    output logic                 slope_up,
    output logic                 slope_dn
);
    logic [VW-1:0]      v_prev;
    logic               prev_vld;
    logic               prev_pos;
    logic               prev_neg;
    logic signed [VW:0] thr_s;
    logic signed [VW:0] neg_err;
    logic signed [VW:0] diff;
    logic               over_pos;
    logic               over_neg;

    // Error, magnitude, band comparison and slope of the current sample.
    always_comb begin
        err      = $signed({1'b0, vref}) - $signed({1'b0, vout});
        neg_err  = -err;
        err_mag  = err[VW] ? neg_err : err;
        thr_s    = $signed({1'b0, thresh});
        over_pos = err > thr_s;
        over_neg = err < -thr_s;
        diff     = $signed({1'b0, vout}) - $signed({1'b0, v_prev});
        slope_up = prev_vld && (diff > 0);
        slope_dn = prev_vld && (diff < 0);
        trig_pos = over_pos && prev_pos;
        trig_neg = over_neg && prev_neg;
    end

    // Remember the previous sample and its band status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_prev   <= '0;
            prev_vld <= 1'b0;
            prev_pos <= 1'b0;
            prev_neg <= 1'b0;
        end else if (smp_vld) begin
            v_prev   <= vout;
            prev_vld <= 1'b1;
            prev_pos <= over_pos;
            prev_neg <= over_neg;
        end
    end
endmodule

// File: rtl/cbc_accum.sv
// Double error accumulator.
// The first sum collects |error| before the extremum. The second collects it
// from the extremum on. The block reports when the second sum, including the
// current sample, reaches the first. Both sums saturate.
// Assumes: load/add controls are already qualified by the sample strobe.
module cbc_accum #(
    parameter int MAG_W = 13,
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load1,
    input  logic             add1,
    input  logic             load2,
    input  logic             add2,
    input  logic [MAG_W-1:0] mag,
    output logic [ACC_W-1:0] acc1,
    output logic             reach
);
    localparam int PAD_W = ACC_W - MAG_W;

    logic [ACC_W-1:0] acc2;
    logic [ACC_W-1:0] mag_x;
    logic [ACC_W-1:0] acc1_sum;
    logic [ACC_W-1:0] acc2_nx;

    // Saturating unsigned add.
    function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] b);
        logic [ACC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[ACC_W] ? {ACC_W{1'b1}} : s[ACC_W-1:0];
    endfunction

    // Next values and the mirror comparison.
    always_comb begin
        mag_x    = {{PAD_W{1'b0}}, mag};
        acc1_sum = sat_add(acc1, mag_x);
        acc2_nx  = load2 ? mag_x : sat_add(acc2, mag_x);
        reach    = acc2_nx >= acc1;
    end

    // Accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc1 <= '0;
            acc2 <= '0;
        end else begin
            if (load1)      acc1 <= mag_x;
            else if (add1)  acc1 <= acc1_sum;
            if (load2 || add2) acc2 <= acc2_nx;
        end
    end
endmodule

// File: rtl/cbc_pwm.sv
// Counter-based pulse-width modulator for linear mode.
// The free-running counter wraps every 2^DUTY_W clocks. The output is high
// while the count is below the duty word.
// Assumes: duty is held stable by its source for a full period.
module cbc_pwm #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_on
);
    logic [DUTY_W-1:0] cnt;

    // Period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Compare against the duty word.
    always_comb pwm_on = cnt < duty;
endmodule

// File: rtl/cbc_ctrl.sv
// Load-step recovery controller, top level.
// Passes the linear duty through a modulator in steady state. On a qualified
// transient it forces the switch, finds the voltage extremum, and toggles once
// when the error sums balance. It returns to linear mode with a duty preload
// once the error has crossed zero. A forced-on sample limit and an abort on an
// opposite-sign transient bound the recovery.
// Assumes: sample_valid is a one-clock strobe per ADC sample.
module cbc_ctrl
    import cbc_pkg::*;
#(
    parameter int VW       = 12,
    parameter int DUTY_W   = 8,
    parameter int ACC_W    = 20,
    parameter int ON_LIMIT = 16,
    parameter int GAIN_SH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [VW-1:0]     vout,
    input  logic [VW-1:0]     vref,
    input  logic [VW-1:0]     thresh,
    input  logic [DUTY_W-1:0] lin_duty,
    output logic              sw_on,
    output logic              mode_nl,
    output logic              preload_vld,
    output logic [DUTY_W-1:0] preload_duty
);
    localparam int MAG_W = VW + 1;
    localparam int OC_W  = $clog2(ON_LIMIT + 1);
    localparam int PAD_W = ACC_W - DUTY_W;
    localparam logic [ACC_W:0] DUTY_MAX = (ACC_W + 1)'((1 << DUTY_W) - 1);

    cbc_state_e         st, st_nx;
    logic               dir_pos, dir_nx;
    logic [DUTY_W-1:0]  base;
    logic [OC_W-1:0]    on_cnt, on_cnt_inc;
    logic signed [VW:0] err;
    logic [VW:0]        err_mag;
    logic               trig_pos, trig_neg, slope_up, slope_dn;
    logic [ACC_W-1:0]   acc1;
    logic               reach;
    logic               load1, add1, load2, add2;
    logic               enter, go_pre;
    logic               pwm_on;
    logic               force_on;
    logic               abort_hit, lim_hit, t1_hit, settled;
    logic [ACC_W-1:0]   delta, base_x;
    logic [ACC_W:0]     up_sum;
    logic [DUTY_W-1:0]  pre_calc;

    cbc_detect #(.VW(VW)) i_detect (
        .clk(clk), .rst_n(rst_n), .smp_vld(sample_valid),
        .vout(vout), .vref(vref), .thresh(thresh),
        .err(err), .err_mag(err_mag),
        .trig_pos(trig_pos), .trig_neg(trig_neg),
        .slope_up(slope_up), .slope_dn(slope_dn)
    );

    cbc_accum #(.MAG_W(MAG_W), .ACC_W(ACC_W)) i_accum (
        .clk(clk), .rst_n(rst_n),
        .load1(load1), .add1(add1), .load2(load2), .add2(add2),
        .mag(err_mag), .acc1(acc1), .reach(reach)
    );

    cbc_pwm #(.DUTY_W(DUTY_W)) i_pwm (
        .clk(clk), .rst_n(rst_n), .duty(lin_duty), .pwm_on(pwm_on)
    );

    // Event decode for the current phase and direction.
    always_comb begin
        force_on   = (st != ST_LIN) && (dir_pos ^ (st == ST_TAIL));
        on_cnt_inc = on_cnt + 1'b1;
        abort_hit  = (st != ST_LIN) && (dir_pos ? trig_neg : trig_pos);
        lim_hit    = force_on && (on_cnt_inc == OC_W'(ON_LIMIT));
        t1_hit     = dir_pos ? slope_up : slope_dn;
        settled    = dir_pos ? (err <= 0) : (err >= 0);
    end

    // Phase transitions and accumulator controls, taken only on a sample.
    always_comb begin
        st_nx  = st;
        dir_nx = dir_pos;
        load1  = 1'b0;
        add1   = 1'b0;
        load2  = 1'b0;
        add2   = 1'b0;
        enter  = 1'b0;
        go_pre = 1'b0;
        if (sample_valid) begin
            if (st == ST_LIN) begin
                if (trig_pos || trig_neg) begin
                    st_nx  = ST_DIVE;
                    dir_nx = trig_pos;
                    load1  = 1'b1;
                    enter  = 1'b1;
                end
            end else if (abort_hit) begin
                st_nx = ST_LIN;
            end else if (lim_hit) begin
                if (st == ST_TAIL) begin
                    st_nx  = ST_LIN;
                    go_pre = 1'b1;
                end else begin
                    st_nx = ST_TAIL;
                    add1  = (st == ST_DIVE);
                end
            end else begin
                unique case (st)
                    ST_DIVE: begin
                        if (t1_hit) begin
                            load2 = 1'b1;
                            st_nx = reach ? ST_TAIL : ST_HOLD;
                        end else begin
                            add1 = 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        add2 = 1'b1;
                        if (reach) st_nx = ST_TAIL;
                    end
                    ST_TAIL: begin
                        if (settled) begin
                            st_nx  = ST_LIN;
                            go_pre = 1'b1;
                        end
                    end
                    default: st_nx = ST_LIN;
                endcase
            end
        end
    end

    // Corrected duty from the entry duty and the pre-extremum sum.
    always_comb begin
        delta  = acc1 >> GAIN_SH;
        base_x = {{PAD_W{1'b0}}, base};
        up_sum = {1'b0, base_x} + {1'b0, delta};
        if (dir_pos)
            pre_calc = (up_sum > DUTY_MAX) ? {DUTY_W{1'b1}} : up_sum[DUTY_W-1:0];
        else if (delta >= base_x)
            pre_calc = '0;
        else
            pre_calc = base - delta[DUTY_W-1:0];
    end

    // Phase, direction, entry duty and forced-on sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_LIN;
            dir_pos <= 1'b0;
            base    <= '0;
            on_cnt  <= '0;
        end else begin
            st      <= st_nx;
            dir_pos <= dir_nx;
            if (enter) begin
                base   <= lin_duty;
                on_cnt <= '0;
            end else if (sample_valid && force_on) begin
                on_cnt <= on_cnt_inc;
            end
        end
    end

    // Preload strobe and value toward the linear compensator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_vld  <= 1'b0;
            preload_duty <= '0;
        end else begin
            preload_vld <= go_pre;
            if (go_pre) preload_duty <= pre_calc;
        end
    end

    // Switch source selection and mode flag.
    always_comb begin
        mode_nl = (st != ST_LIN);
        sw_on   = mode_nl ? force_on : pwm_on;
    end
endmodule

// File: rtl/cbc_ctrl_chk.sv
// Property checker for cbc_ctrl, attached by bind.
// Tracks forced-on samples with its own counter so the limit window does not
// depend on a parameter-sized delay.
module cbc_ctrl_chk #(
    parameter int ON_LIMIT = 16
) (
    input logic clk,
    input logic rst_n,
    input logic sample_valid,
    input logic sw_on,
    input logic mode_nl,
    input logic preload_vld
);
    localparam int CW = $clog2(ON_LIMIT + 2);
    logic [CW-1:0] fon_cnt;

    // Count samples taken while the switch is forced on.
    always_ff @(posedge clk) begin
        if (!rst_n || !(mode_nl && sw_on)) fon_cnt <= '0;
        else if (sample_valid)             fon_cnt <= fon_cnt + 1'b1;
    end

    assert_preload_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        preload_vld |-> (!mode_nl && $past(mode_nl)));

    assert_preload_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        preload_vld |=> !preload_vld);

    assert_mode_on_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(mode_nl));

    assert_force_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_nl && !sample_valid) |=> $stable(sw_on));

    assert_on_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fon_cnt <= CW'(ON_LIMIT));
endmodule

bind cbc_ctrl cbc_ctrl_chk #(.ON_LIMIT(ON_LIMIT)) i_cbc_ctrl_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .sw_on(sw_on), .mode_nl(mode_nl), .preload_vld(preload_vld)
);

// File: tb/test_cbc_ctrl.sv
// Scoreboard bench: the driver queues the expected mode and switch state for
// each sample, and the expected duty for each preload. Monitors compare them.
module test_cbc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int VREF       = 2048;
    localparam int ON_LIM     = 8;

    typedef struct {
        bit    m;
        bit    s;
        bit    cs;
        string r;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] vout = 12'(VREF);
    logic [11:0] vref = 12'(VREF);
    logic [11:0] thresh = 12'd20;
    logic [7:0]  lin_duty = 8'd64;
    logic        sw_on, mode_nl, preload_vld;
    logic [7:0]  preload_duty;

    int    checks = 0;
    int    errors = 0;
    bit    seen = 1'b0;
    bit    done = 1'b0;
    item_t exp_q[$];
    item_t it;
    int    pre_q[$];
    string pre_r[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cbc_ctrl #(.VW(12), .DUTY_W(8), .ACC_W(20), .ON_LIMIT(ON_LIM), .GAIN_SH(2)) i_cbc_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .vout(vout), .vref(vref), .thresh(thresh), .lin_duty(lin_duty),
        .sw_on(sw_on), .mode_nl(mode_nl),
        .preload_vld(preload_vld), .preload_duty(preload_duty)
    );

    // Mark the edges that captured a sample.
    always @(posedge clk) seen <= sample_valid;

    // Monitor: compare results one clock after each sampling edge.
    always @(negedge clk) begin
        if (seen) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 sample result with no expectation");
            end else begin
                it = exp_q.pop_front();
                checks++;
                if (mode_nl !== it.m || (it.cs && sw_on !== it.s)) begin
                    errors++;
                    $display("FAIL %s mode/sw actual %0b/%0b expected %0b/%0b",
                             it.r, mode_nl, sw_on, it.m, it.s);
                end
            end
        end
        if (rst_n && preload_vld) begin
            checks++;
            if (pre_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected preload actual %0d expected none", preload_duty);
            end else begin
                if (preload_duty !== 8'(pre_q[0])) begin
                    errors++;
                    $display("FAIL %s preload actual %0d expected %0d",
                             pre_r[0], preload_duty, pre_q[0]);
                end
                void'(pre_q.pop_front());
                void'(pre_r.pop_front());
            end
        end
    end

    // Driver: one sample with error e, plus its expected outcome.
    task automatic smp(input int e, input bit m, input bit s, input bit cs, input string r);
        @(negedge clk);
        vout = 12'(VREF - e);
        sample_valid = 1'b1;
        exp_q.push_back('{m: m, s: s, cs: cs, r: r});
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic exp_pre(input int v, input string r);
        pre_q.push_back(v);
        pre_r.push_back(r);
    endtask

    // Count switch-on cycles over one full modulator period (R1).
    task automatic pwm_win(input int exp_on);
        int on_n = 0;
        bit nl = 1'b0;
        repeat (256) begin
            @(negedge clk);
            if (sw_on) on_n++;
            if (mode_nl) nl = 1'b1;
        end
        checks++;
        if (on_n != exp_on || nl) begin
            errors++;
            $display("FAIL R1 on-cycles actual %0d expected %0d (nl %0b)", on_n, exp_on, nl);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (mode_nl !== 1'b0 || preload_vld !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset mode/preload actual %0b/%0b expected 0/0", mode_nl, preload_vld);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (mode_nl !== 1'b0) begin
            errors++;
            $display("FAIL R11 after reset mode actual %0b expected 0", mode_nl);
        end

        // R1: linear pass-through.
        pwm_win(64);

        // R2: isolated band excursions are ignored.
        smp(0, 0, 0, 0, "R2 idle");
        smp(30, 0, 0, 0, "R2 single positive");
        smp(0, 0, 0, 0, "R2 back in band");
        smp(-30, 0, 0, 0, "R2 single negative");
        smp(0, 0, 0, 0, "R2 back in band");

        // Undershoot recovery: sums 40+50+55=145, toggle when 52+45+35+25>=145.
        exp_pre(100, "R7 undershoot 64+145/4");
        smp(30, 0, 0, 0, "R2 first excursion");
        smp(40, 1, 1, 1, "R2 R3 entry forces on");
        smp(50, 1, 1, 1, "R3 falling");
        smp(55, 1, 1, 1, "R9 same-sign retrigger ignored");
        smp(52, 1, 1, 1, "R4 extremum, hold");
        smp(45, 1, 1, 1, "R5 sum 97");
        smp(35, 1, 1, 1, "R5 sum 132");
        smp(25, 1, 0, 1, "R5 sum 157 toggles");
        smp(10, 1, 0, 1, "R6 not yet crossed");
        smp(0, 0, 0, 0, "R6 crossed, linear");

        // Overshoot recovery with floor: sums 40+50=90, 45+30+20>=90; 10-22 -> 0.
        lin_duty = 8'd10;
        smp(0, 0, 0, 0, "R2 idle");
        exp_pre(0, "R7 overshoot floor");
        smp(-30, 0, 0, 0, "R2 first excursion");
        smp(-40, 1, 0, 1, "R3 entry forces off");
        smp(-50, 1, 0, 1, "R4 still rising");
        smp(-45, 1, 0, 1, "R4 extremum, hold");
        smp(-30, 1, 0, 1, "R5 sum 75");
        smp(-20, 1, 1, 1, "R5 sum 95 toggles on");
        smp(-5, 1, 1, 1, "R6 not yet crossed");
        smp(0, 0, 0, 0, "R6 crossed, linear");

        // Forced-on limit: sum 40+50..120 = 720; 200+180 saturates to 255.
        lin_duty = 8'd200;
        smp(0, 0, 0, 0, "R2 idle");
        exp_pre(255, "R7 saturated preload");
        smp(30, 0, 0, 0, "R2 first excursion");
        smp(40, 1, 1, 1, "R3 entry");
        for (int k = 0; k < 7; k++) smp(50 + 10*k, 1, 1, 1, "R8 under limit");
        smp(120, 1, 0, 1, "R8 limit forces off");
        smp(0, 0, 0, 0, "R6 after limit, linear");

        // Opposite-sign transient aborts without preload.
        lin_duty = 8'd64;
        smp(0, 0, 0, 0, "R2 idle");
        smp(30, 0, 0, 0, "R2 first excursion");
        smp(40, 1, 1, 1, "R3 entry");
        smp(-30, 1, 1, 1, "R9 reversal, still forced");
        smp(-40, 0, 0, 0, "R9 opposite transient aborts");
        smp(0, 0, 0, 0, "R9 stays linear");
        repeat (4) @(negedge clk);

        checks++;
        if (pre_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing preloads actual %0d expected 0", pre_q.size());
        end
        pwm_win(64);
        lin_duty = 8'd200;
        pwm_win(200);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule